// File: doc/BRIEF.md
# Phase-Synchronized Up-Down PWM Channel

This block is one PWM channel. Its time base is a counter that ramps from zero up to a programmed period and back down to zero, over and over. Each time the counter is at zero, the channel raises a one-cycle sync output. Another channel can take that pulse on its sync input. On every sync input pulse, the counter is loaded with a programmable phase value. This lets a master and any number of slaves run at fixed, adjustable phase offsets.

Counter events drive one output through a small action table. The events are zero, period, compare A while rising, compare A while falling, compare B while rising and compare B while falling. Each event can leave the output alone, clear it, set it, or toggle it. Compare events match on equality only. So a phase load that moves the counter past compare A skips that edge. Compare B can be placed a little below compare A as a backstop that catches such a skipped clear. The zero event is the last line of defence.

Software writes the registers through a simple write port. Period, both compares and phase are staged in holding registers and take effect when the counter reaches zero. The action table takes effect at once.

Top module: `pwm_phase_sync`

## Requirements
- R1: The counter steps 0,1,…,P,P-1,…,1,0,1,… for a programmed period P>0. With no sync input, sync_out is high for exactly one cycle in every 2·P cycles.
- R2: sync_out is high in exactly the cycles where the counter is zero. A sync_in pulse loads the counter with the active phase value on the next clock, and the counter then counts down. In a chained slave with phase Q, the slave's sync_out follows the master's sync_out by Q+1 cycles.
- R3: With P=20, compare A=10, and the action codes zero→clear, period→set, A-rising→set and A-falling→clear, the output forms high pulses of 2·(P−A)=20 cycles. The output registers the action one cycle after the event cycle.
- R4: Each action field holds a 2-bit code: 00 does nothing, 01 clears, 10 sets and 11 toggles. With only zero→toggle programmed, high pulses last 2·P cycles.
- R5: When a phase load moves a falling counter from above compare A to below it, no A-falling event occurs. With compare B actions off, the output stays high until the zero-event clear.
- R6: With compare B below compare A and B-falling→clear, a phase load that lands between B and A clears the output at the B match instead. That pulse is shortened to end one cycle after the counter passes B.
- R7: When the phase load lands below compare B, both compare edges are skipped and the zero event clears the output.
- R8: When several events hit in one cycle, they apply in this order: zero, then period, then compare B, then compare A. The last one applied wins. So compare A overrides compare B on the same count.
- R9: A new period, compare or phase value written through the port takes effect only when the counter next reaches zero. A phase written during a high pulse leaves that pulse unchanged.
- R10: Write address map: 0 period, 1 compare A, 2 compare B, 3 phase, 4 action table. The action table uses bits [1:0] zero, [3:2] period, [5:4] A-rising, [7:6] A-falling, [9:8] B-rising and [11:10] B-falling. The bench uses codes 0x069, 0x569, 0x169 and 0x003.
- R11: During reset the output is low, the counter is zero (so sync_out is high), and all registers are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | Phase-load request |
| sync_out | output | 1 | High while the counter is zero |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds two copies with the default 16-bit counter and chains the master's sync_out into the slave's sync_in. Both use period 20, compare A 10 and compare B 7. These small values keep each carrier cycle at 40 clocks, so a phase sweep from 15 down to 8 or 6 lands the slave counter between or below the two compares within a few hundred cycles. That makes the skipped edge, the backstop edge and the zero fallback all measurable as distinct pulse lengths (23, 16 and 21 against a nominal 20).

// File: rtl/pwm_phase_sync.sv
`timescale 1ns/1ps
module pwm_phase_sync #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             sync_in,
  output logic             sync_out,
  output logic             pwm_out
);
  localparam int ACT_W = 12;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] prd_sh, ca_sh, cb_sh, ph_sh;
  logic [CNT_W-1:0] prd_act, ca_act, cb_act, ph_act;
  logic [CNT_W-1:0] cnt;
  logic [ACT_W-1:0] act;
  logic             dir_up, pwm_q, pwm_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_sh <= '0; ca_sh <= '0; cb_sh <= '0; ph_sh <= '0; act <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: prd_sh <= wr_data;
        3'd1: ca_sh  <= wr_data;
        3'd2: cb_sh  <= wr_data;
        3'd3: ph_sh  <= wr_data;
        3'd4: act    <= wr_data[ACT_W-1:0];
        default: ;
      endcase
    end
  end

  wire at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_act <= '0; ca_act <= '0; cb_act <= '0; ph_act <= '0;
    end else if (at_zero) begin
      prd_act <= prd_sh; ca_act <= ca_sh; cb_act <= cb_sh; ph_act <= ph_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      dir_up <= 1'b0;
    end else if (sync_in) begin
      cnt <= ph_act;
      dir_up <= 1'b0;
    end else if (dir_up) begin
      if (cnt >= prd_act) begin
        dir_up <= 1'b0;
        if (!at_zero) cnt <= cnt - ONE;
      end else begin
        cnt <= cnt + ONE;
      end
    end else begin
      if (at_zero) begin
        dir_up <= 1'b1;
        if (prd_act != '0) cnt <= ONE;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  wire at_prd  = (cnt == prd_act);
  wire ca_up   =  dir_up && (cnt == ca_act);
  wire ca_dn   = !dir_up && (cnt == ca_act);
  wire cb_up   =  dir_up && (cnt == cb_act);
  wire cb_dn   = !dir_up && (cnt == cb_act);
  wire any_ev  = at_zero | at_prd | ca_up | ca_dn | cb_up | cb_dn;

  function automatic logic apply(input logic cur, input logic [1:0] code);
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  always_comb begin
    pwm_nxt = pwm_q;
    if (at_zero) pwm_nxt = apply(pwm_nxt, act[1:0]);
    if (at_prd)  pwm_nxt = apply(pwm_nxt, act[3:2]);
    if (cb_up)   pwm_nxt = apply(pwm_nxt, act[9:8]);
    if (cb_dn)   pwm_nxt = apply(pwm_nxt, act[11:10]);
    if (ca_up)   pwm_nxt = apply(pwm_nxt, act[5:4]);
    if (ca_dn)   pwm_nxt = apply(pwm_nxt, act[7:6]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_nxt;
  end

  assign pwm_out  = pwm_q;
  assign sync_out = at_zero;

  a_r2_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (cnt == $past(ph_act)) && !dir_up);

  a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_up && !at_zero && !sync_in) |=> cnt == $past(cnt) - ONE);

  a_r1_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_up && cnt >= prd_act && !sync_in) |=> !dir_up);

  a_r9_shadow_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero |=> $stable(prd_act) && $stable(ca_act) && $stable(cb_act) && $stable(ph_act));

  a_r4_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ev |=> $stable(pwm_q));

  a_r8_compare_a_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_up && act[5:4] == 2'b10) |=> pwm_q);
endmodule

// File: tb/test_pwm_phase_sync.sv
`timescale 1ns/1ps
module test_pwm_phase_sync;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_we = 1'b0, s_we = 1'b0;
  logic [2:0] m_wa = '0, s_wa = '0;
  logic [W-1:0] m_wd = '0, s_wd = '0;
  logic m_sync, s_sync, m_pwm, s_pwm;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct { int w; string tag; } exp_t;
  exp_t sq[$];
  exp_t mq[$];

  always #5 clk = ~clk;

  pwm_phase_sync #(.CNT_W(W)) i_pwm_phase_sync (
    .clk(clk), .rst_n(rst_n), .wr_en(m_we), .wr_addr(m_wa), .wr_data(m_wd),
    .sync_in(1'b0), .sync_out(m_sync), .pwm_out(m_pwm));

  pwm_phase_sync #(.CNT_W(W)) i_pwm_phase_sync_s (
    .clk(clk), .rst_n(rst_n), .wr_en(s_we), .wr_addr(s_wa), .wr_data(s_wd),
    .sync_in(m_sync), .sync_out(s_sync), .pwm_out(s_pwm));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit slv, input logic [2:0] a, input int d);
    @(negedge clk);
    if (slv) begin s_we = 1'b1; s_wa = a; s_wd = W'(d); end
    else     begin m_we = 1'b1; m_wa = a; m_wd = W'(d); end
    @(negedge clk);
    s_we = 1'b0; m_we = 1'b0;
  endtask

  task automatic push(input bit slv, input int w, input string tag);
    exp_t e;
    e.w = w; e.tag = tag;
    if (slv) sq.push_back(e); else mq.push_back(e);
  endtask

  task automatic wait_rise(input bit slv);
    logic p;
    bit hit;
    @(negedge clk);
    p = slv ? s_pwm : m_pwm;
    hit = 1'b0;
    while (!hit) begin
      @(negedge clk);
      hit = (slv ? s_pwm : m_pwm) && !p;
      p = slv ? s_pwm : m_pwm;
    end
  endtask

  task automatic drain();
    while (sq.size() != 0 || mq.size() != 0) @(negedge clk);
  endtask

  initial begin
    int w = 0;
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin w = 0; prev = 1'b0; end
      else begin
        if (s_pwm) w++;
        else if (prev) begin
          if (sq.size() > 0) begin
            exp_t e;
            e = sq.pop_front();
            chk(w == e.w, {"slave pulse ", e.tag}, w, e.w);
          end
          w = 0;
        end
        prev = s_pwm;
      end
    end
  end

  initial begin
    int w = 0;
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin w = 0; prev = 1'b0; end
      else begin
        if (m_pwm) w++;
        else if (prev) begin
          if (mq.size() > 0) begin
            exp_t e;
            e = mq.pop_front();
            chk(w == e.w, {"master pulse ", e.tag}, w, e.w);
          end
          w = 0;
        end
        prev = m_pwm;
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired, all requirements actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(m_pwm == 1'b0, "R11 master output low in reset", int'(m_pwm), 0);
    chk(s_pwm == 1'b0, "R11 slave output low in reset", int'(s_pwm), 0);
    chk(m_sync == 1'b1, "R11 master counter zero in reset", int'(m_sync), 1);
    chk(s_sync == 1'b1, "R11 slave counter zero in reset", int'(s_sync), 1);
    rst_n = 1'b1;

    // R10 register map: slave first, phase last; then master
    wr(1, 3'd0, 20); wr(1, 3'd1, 10); wr(1, 3'd2, 7); wr(1, 3'd4, 'h069);
    wr(1, 3'd3, 15);
    wr(0, 3'd1, 10); wr(0, 3'd4, 'h069); wr(0, 3'd0, 20);
    repeat (300) @(negedge clk);

    // R1 carrier length and sync width
    while (!m_sync) @(negedge clk);
    @(negedge clk);
    chk(m_sync == 1'b0, "R1 sync one cycle wide", int'(m_sync), 0);
    k = 1;
    while (!m_sync) begin @(negedge clk); k++; end
    chk(k == 40, "R1 sync spacing 2*P", k, 40);

    // R2 slave offset from phase load
    @(negedge clk);
    while (!m_sync) @(negedge clk);
    k = 0;
    do begin @(negedge clk); k++; end while (!s_sync);
    chk(k == 16, "R2 slave sync lag phase+1", k, 16);

    // R3 nominal pulses
    wait_rise(1);
    push(1, 20, "R3 nominal"); push(1, 20, "R3 nominal");
    wait_rise(0);
    push(0, 20, "R3 master nominal");
    drain();

    // R5 missed edge, compare B off; R9 shadowed phase
    wait_rise(1);
    push(1, 20, "R9 current pulse untouched");
    push(1, 23, "R5 missed compare A, zero clears");
    push(1, 20, "R3 new phase steady");
    wr(1, 3'd3, 8);
    drain();

    // R6 compare B backstop
    wr(1, 3'd4, 'h569); wr(1, 3'd3, 15);
    repeat (4) wait_rise(1);
    wait_rise(1);
    push(1, 20, "R9 current pulse untouched");
    push(1, 16, "R6 compare B recovers clear");
    push(1, 20, "R6 steady after recovery");
    wr(1, 3'd3, 8);
    drain();

    // R7 step larger than gap
    wr(1, 3'd3, 15);
    repeat (4) wait_rise(1);
    wait_rise(1);
    push(1, 20, "R9 current pulse untouched");
    push(1, 21, "R7 zero fallback");
    push(1, 20, "R7 steady after fallback");
    wr(1, 3'd3, 6);
    drain();

    // R8 compare A beats compare B on same count
    wr(0, 3'd2, 10); wr(0, 3'd4, 'h169);
    repeat (3) wait_rise(0);
    wait_rise(0);
    push(0, 20, "R8 compare A wins"); push(0, 20, "R8 compare A wins");
    drain();

    // R4 toggle code
    wr(0, 3'd4, 'h003);
    wait_rise(0);
    push(0, 40, "R4 toggle at zero");
    drain();

    chk(sq.size() == 0 && mq.size() == 0, "R3 scoreboard drained",
        sq.size() + mq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule